// File: doc/BRIEF.md
# Ethernet receive address filter

This block makes the keep-or-discard decision for each incoming Ethernet frame. A receive path presents a frame's 48-bit destination address and its length, with a one-cycle `in_valid` strobe. The block checks the length first. It then sorts the destination into one of three kinds: unicast, multicast or broadcast. Each kind is judged against the mode bits in a 32-bit control word, the programmed station address and a 64-entry multicast hash table. A receive-everything mode skips the address checks.

The multicast hash index comes from a parallel CRC-32 stage inside the block. The CRC is computed over the six destination bytes. The decision is registered. It appears one cycle after the strobe, together with a status word whose flag bits let a downstream receive engine record the frame kind.

Top module: `rx_addr_filter`

## Requirements
- R1: The decision registers reset to zero. A strobe on `in_valid` produces `dec_valid` high on the next cycle, for exactly one cycle per strobe. While `dec_valid` is low, `dec_accept` and `dec_status` are zero.
- R2: A frame whose length is below 10 bytes is always dropped, whatever the control word holds, including receive-all.
- R3: A frame of 10 to 63 bytes is dropped unless control bit 12 (short-frame accept) is set.
- R4: When control bit 14 (receive-all) is set, a frame that passes the length rules is accepted whatever its destination.
- R5: A broadcast destination (all 48 bits one) is accepted, when receive-all is clear, only if control bit 17 is set.
- R6: A multicast destination has bit 0 of the first address byte set and is not broadcast. It is accepted outright when control bit 16 is set.
- R7: With bit 16 clear, a multicast frame is accepted only when control bit 15 is set and the selected hash bit is one. The hash index i is bits 31:26 of a CRC-32 over the six destination bytes. The CRC starts at all ones, takes byte 0 first with each byte least significant bit first, uses the reflected polynomial 0xEDB88320, and has no final inversion. Index i selects bit i%32 of hash word i/32: word 0 is `hash_w0`, word 1 is `hash_w1`.
- R8: A unicast destination is accepted only when all six bytes equal the station address. `sta_hi` bits 15:8 and 7:0 hold bytes 0 and 1. `sta_lo` bits 31:24, 23:16, 15:8 and 7:0 hold bytes 2 to 5. Byte 0 is `in_dest[47:40]`.
- R9: An accepted broadcast frame sets `dec_status` bit 17. An accepted multicast frame sets bit 16. All other status bits are zero, and the status is zero for a dropped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 32 | Mode bits (12, 14, 15, 16, 17 used) |
| sta_hi | input | 32 | Station address bytes 0 and 1 |
| sta_lo | input | 32 | Station address bytes 2 to 5 |
| hash_w0 | input | 32 | Hash table entries 0 to 31 |
| hash_w1 | input | 32 | Hash table entries 32 to 63 |
| in_valid | input | 1 | Frame header present this cycle |
| in_dest | input | 48 | Destination address, byte 0 in bits 47:40 |
| in_len | input | 16 | Frame length in bytes |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | Frame accepted |
| dec_status | output | 32 | Receive status flags (bits 17, 16) |

## Verification
The assertions compare each decision with the inputs that were sampled one edge earlier. They therefore assume that the control word, the station address and the hash words are held steady around a strobe and change only between frames. The stimulus keeps to this: every scenario task writes the configuration before it raises `in_valid`, and drives inputs only on the falling edge. They also assume that `in_len` and `in_dest` are meaningful only in a strobe cycle. Both are driven to fixed values alongside each strobe.

// File: rtl/rx_filt_pkg.sv
package rx_filt_pkg;
   localparam int CTL_RUNT_OK  = 12;
   localparam int CTL_RX_ALL   = 14;
   localparam int CTL_HASH_EN  = 15;
   localparam int CTL_MCAST_EN = 16;
   localparam int CTL_BCAST_EN = 17;
   localparam int STS_MCAST    = 16;
   localparam int STS_BCAST    = 17;
   localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

   typedef enum logic [1:0] {
      DST_UCAST = 2'd0,
      DST_MCAST = 2'd1,
      DST_BCAST = 2'd2
   } dst_kind_e;
endpackage

// File: rtl/rx_filt_hash.sv
module rx_filt_hash
   import rx_filt_pkg::*;
#(
   parameter int ADDR_BYTES = 6,
   parameter int IDX_W      = 6
) (
   input  logic [8*ADDR_BYTES-1:0] addr,
   output logic [IDX_W-1:0]        idx
);
   localparam int NBITS = 8 * ADDR_BYTES;

   logic [31:0] chain [0:NBITS];

   assign chain[0] = 32'hFFFF_FFFF;

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_byte
      for (genvar k = 0; k < 8; k++) begin : g_bit
         localparam int STEP = 8 * b + k;
         localparam int SRC  = NBITS - 8 * (b + 1) + k;
         logic fb;
         assign fb = chain[STEP][0] ^ addr[SRC];
         assign chain[STEP+1] = (chain[STEP] >> 1) ^ (fb ? CRC_POLY : 32'd0);
      end
   end

   assign idx = chain[NBITS][31 -: IDX_W];
endmodule

// File: rtl/rx_filt_match.sv
module rx_filt_match
   import rx_filt_pkg::*;
#(
   parameter int ADDR_BYTES = 6
) (
   input  logic [8*ADDR_BYTES-1:0] addr,
   input  logic [8*ADDR_BYTES-1:0] station,
   output dst_kind_e               kind,
   output logic                    sta_hit
);
   logic [ADDR_BYTES-1:0] byte_eq;

   for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_cmp
      assign byte_eq[b] = (addr[8*b +: 8] == station[8*b +: 8]);
   end

   assign sta_hit = &byte_eq;

   always_comb begin
      if (&addr)
         kind = DST_BCAST;
      else if (addr[8*ADDR_BYTES-8])
         kind = DST_MCAST;
      else
         kind = DST_UCAST;
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rx_filt_pkg::*;
#(
   parameter int LEN_W    = 16,
   parameter int TINY_LEN = 10,
   parameter int RUNT_LEN = 64,
   parameter int IDX_W    = 6
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] ctrl_word,
   input  logic [31:0] sta_hi,
   input  logic [31:0] sta_lo,
   input  logic [31:0] hash_w0,
   input  logic [31:0] hash_w1,
   input  logic        in_valid,
   input  logic [47:0] in_dest,
   input  logic [15:0] in_len,
   output logic        dec_valid,
   output logic        dec_accept,
   output logic [31:0] dec_status
);
   localparam int ADDR_BYTES = 6;
   localparam int TBL_SIZE   = 1 << IDX_W;

   if (IDX_W != 6) begin : g_bad_idx
      $error("rx_addr_filter: hash table is two 32-bit words, IDX_W must be 6");
   end
   if (TINY_LEN >= RUNT_LEN || LEN_W != 16) begin : g_bad_len
      $error("rx_addr_filter: length limits inconsistent");
   end

   logic [47:0]         station;
   logic [TBL_SIZE-1:0] table_bits;
   logic [IDX_W-1:0]    hash_idx;
   dst_kind_e           kind;
   logic                sta_hit;
   logic                len_ok, addr_ok, accept_d;
   logic [31:0]         status_d;

   assign station    = {sta_hi[15:0], sta_lo};
   assign table_bits = {hash_w1, hash_w0};

   rx_filt_hash #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_hash (
      .addr (in_dest),
      .idx  (hash_idx)
   );

   rx_filt_match #(.ADDR_BYTES(ADDR_BYTES)) u_match (
      .addr    (in_dest),
      .station (station),
      .kind    (kind),
      .sta_hit (sta_hit)
   );

   always_comb begin
      if (in_len < LEN_W'(TINY_LEN))
         len_ok = 1'b0;
      else if (in_len < LEN_W'(RUNT_LEN))
         len_ok = ctrl_word[CTL_RUNT_OK];
      else
         len_ok = 1'b1;
   end

   always_comb begin
      unique case (kind)
         DST_BCAST: addr_ok = ctrl_word[CTL_BCAST_EN];
         DST_MCAST: addr_ok = ctrl_word[CTL_MCAST_EN] ||
                              (ctrl_word[CTL_HASH_EN] && table_bits[hash_idx]);
         default:   addr_ok = sta_hit;
      endcase
   end

   assign accept_d = len_ok && (ctrl_word[CTL_RX_ALL] || addr_ok);

   always_comb begin
      status_d = '0;
      status_d[STS_BCAST] = accept_d && (kind == DST_BCAST);
      status_d[STS_MCAST] = accept_d && (kind == DST_MCAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
         dec_status <= '0;
      end else begin
         dec_valid  <= in_valid;
         dec_accept <= in_valid && accept_d;
         dec_status <= in_valid ? status_d : 32'd0;
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> dec_valid);
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_valid |-> (!dec_accept && dec_status == 32'd0));
   a_r2_tiny_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_len < 16'(TINY_LEN)) |=> !dec_accept);
   a_r3_runt_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_len < 16'(RUNT_LEN) && !ctrl_word[CTL_RUNT_OK]) |=> !dec_accept);
   a_r4_rx_all: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && ctrl_word[CTL_RX_ALL] && in_len >= 16'(RUNT_LEN)) |=> dec_accept);
   a_r5_bcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (&in_dest) && !ctrl_word[CTL_BCAST_EN] && !ctrl_word[CTL_RX_ALL])
      |=> !dec_accept);
   a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dec_status[STS_BCAST:STS_MCAST]));
   a_r9_flag_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_status != 32'd0) |-> dec_accept);
endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ctrl_word = '0, sta_hi = '0, sta_lo = '0, hash_w0 = '0, hash_w1 = '0;
   logic        in_valid = 1'b0;
   logic [47:0] in_dest = '0;
   logic [15:0] in_len = '0;
   logic        dec_valid, dec_accept;
   logic [31:0] dec_status;

   int total = 0;
   int bad = 0;

   always #2.5 clk = ~clk;

   rx_addr_filter dut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .sta_hi(sta_hi),
      .sta_lo(sta_lo), .hash_w0(hash_w0), .hash_w1(hash_w1),
      .in_valid(in_valid), .in_dest(in_dest), .in_len(in_len),
      .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_status(dec_status)
   );

   localparam logic [47:0] STATION = 48'h02_11_22_33_44_55;
   localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] MCAST   = 48'h01_00_5E_12_34_56;

   function automatic logic [5:0] ref_idx(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int b = 0; b < 6; b++) begin
         c ^= {24'd0, a[47-8*b -: 8]};
         for (int k = 0; k < 8; k++)
            c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
      end
      return c[31:26];
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(input logic [31:0] c);
      @(negedge clk);
      ctrl_word = c;
      sta_hi    = {16'd0, STATION[47:32]};
      sta_lo    = STATION[31:0];
   endtask

   task automatic frame(input logic [47:0] d, input logic [15:0] len,
                        input string req, input logic exp_acc, input logic [31:0] exp_sts);
      @(negedge clk);
      in_valid = 1'b1; in_dest = d; in_len = len;
      @(negedge clk);
      in_valid = 1'b0;
      check({req, " valid"}, {31'd0, dec_valid}, 32'd1);
      check({req, " accept"}, {31'd0, dec_accept}, {31'd0, exp_acc});
      check({req, " status"}, dec_status, exp_sts);
      @(negedge clk);
      check({req, " one-shot"}, {31'd0, dec_valid}, 32'd0);
   endtask

   task automatic t_reset();
      check("R1 reset valid", {31'd0, dec_valid}, 32'd0);
      check("R1 reset accept", {31'd0, dec_accept}, 32'd0);
      check("R1 reset status", dec_status, 32'd0);
   endtask

   task automatic t_tiny();
      cfg(32'h0003_D000);
      frame(BCAST, 16'd9, "R2 tiny all modes", 1'b0, 32'd0);
      frame(STATION, 16'd10, "R2 len10 runt ok", 1'b1, 32'd0);
   endtask

   task automatic t_runt();
      cfg(32'h0000_0000);
      frame(STATION, 16'd63, "R3 runt dropped", 1'b0, 32'd0);
      frame(STATION, 16'd64, "R3 len64 kept", 1'b1, 32'd0);
      cfg(32'h0000_1000);
      frame(STATION, 16'd40, "R3 runt allowed", 1'b1, 32'd0);
   endtask

   task automatic t_rx_all();
      cfg(32'h0000_4000);
      frame(48'h00_AA_BB_CC_DD_EE, 16'd100, "R4 foreign ucast", 1'b1, 32'd0);
      frame(BCAST, 16'd100, "R4 bcast flagged", 1'b1, 32'h0002_0000);
      frame(48'h00_AA_BB_CC_DD_EE, 16'd20, "R4 runt still drops", 1'b0, 32'd0);
   endtask

   task automatic t_bcast();
      cfg(32'h0000_0000);
      frame(BCAST, 16'd64, "R5 bcast off", 1'b0, 32'd0);
      cfg(32'h0002_0000);
      frame(BCAST, 16'd64, "R5 bcast on R9", 1'b1, 32'h0002_0000);
   endtask

   task automatic t_mcast();
      cfg(32'h0001_0000);
      frame(MCAST, 16'd80, "R6 mcast on R9", 1'b1, 32'h0001_0000);
      cfg(32'h0002_0000);
      frame(MCAST, 16'd80, "R6 mcast off", 1'b0, 32'd0);
   endtask

   task automatic t_hash();
      logic [5:0]  i = ref_idx(MCAST);
      logic [63:0] tbl = 64'd1 << i;
      hash_w0 = tbl[31:0]; hash_w1 = tbl[63:32];
      cfg(32'h0000_8000);
      frame(MCAST, 16'd80, "R7 hash hit", 1'b1, 32'h0001_0000);
      hash_w0 = ~tbl[31:0]; hash_w1 = ~tbl[63:32];
      frame(MCAST, 16'd80, "R7 hash miss", 1'b0, 32'd0);
      hash_w0 = tbl[31:0]; hash_w1 = tbl[63:32];
      cfg(32'h0000_0000);
      frame(MCAST, 16'd80, "R7 hash disabled", 1'b0, 32'd0);
      i = ref_idx(48'h33_33_00_00_00_01);
      tbl = 64'd1 << i;
      hash_w0 = tbl[31:0]; hash_w1 = tbl[63:32];
      cfg(32'h0000_8000);
      frame(48'h33_33_00_00_00_01, 16'd80, "R7 second addr", 1'b1, 32'h0001_0000);
   endtask

   task automatic t_ucast();
      cfg(32'h0003_8000);
      frame(STATION, 16'd64, "R8 exact match", 1'b1, 32'd0);
      for (int b = 0; b < 6; b++) begin
         logic [47:0] d = STATION ^ (48'h02 << (8 * b));
         frame(d, 16'd64, $sformatf("R8 byte%0d differs", b), 1'b0, 32'd0);
      end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_tiny();
      t_runt();
      t_rx_all();
      t_bcast();
      t_mcast();
      t_hash();
      t_ucast();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule